// File: doc/BRIEF.md
# Auto-Reload Timer with Prescaler

An 8-bit up-counter for a small microcontroller. It counts ticks from one of three sources: the core clock, the core clock divided by three, or rising edges of an external pin. A power-of-two prescaler sits between the source and the counter. When the counter rolls past its maximum, it reloads from a reload register and raises a sticky overflow flag. A compare register is checked against the live count. While the two are equal, a combinational match output is high, and a sticky compare flag is set.

Software uses a byte-wide register port with a 3-bit index. Index 0 is control, 1 is reload, 2 is compare, 3 is the live counter and 4 is the flags. A selectable edge of the synchronised external pin can also force an immediate reload. The counter is never cleared by reset, so a value written to it survives a reset. Writes to it are accepted even while reset is held.

Top module: `art_timer`

## Requirements
- R1: Reset clears control, reload, compare, both flags, the prescaler and the divide-by-3 phase. The counter is not cleared, does not advance while reset is low, and keeps its value across reset.
- R2: Control bits [7:5] hold a code n. The counter advances once every 2^n source ticks. A free-running 7-bit prescaler is tapped, and changing n never resets it.
- R3: Control bits [1:0] select the source. 00 is every clock. 01 is one clock in three. 10 is each rising edge of the external input after a two-flop synchroniser. 11 stops counting.
- R4: Control bit 4 always reads 0, and writing 1 to it has no effect. Writing 8'hFF to control reads back 8'hEF.
- R5: A write to index 3 sets the counter on the next clock and overrides every other update. A read of index 3 returns the live count.
- R6: A count tick while the counter is 8'hFF loads the reload value instead of wrapping to 0.
- R7: The overflow flag (flags bit 0) sets on that reload and stays set until a write to index 4 with bit 0 high clears it. A new overflow in the same cycle wins over the clear.
- R8: Control bit 2 enables edge reload, and bit 3 picks the edge (0 rising, 1 falling). A detected edge of the synchronised input loads the reload value. This takes priority over a count tick.
- R9: `cmp_hit` is high while count equals compare. The compare flag (flags bit 1) sets on the clock after equality and holds until a write to index 4 with bit 1 high clears it. A new match wins over the clear.
- R10: Indices 0–2 read back their registers. Index 4 reads {6'b0, compare flag, overflow flag}. Indices 5–7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational on addr) |
| ext_in | input | 1 | Asynchronous external timer input |
| cmp_hit | output | 1 | Count equals compare |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bound assertions check these on every cycle:
- the reload on overflow and the overflow flag it sets;
- the stickiness of the flags;
- the compare flag following equality;
- the frozen count under source 11;
- the override by a counter write;
- the edge reload;
- that count ticks only occur with a source tick.

Tick spacing under each prescaler code, the divide-by-3 phase, synchroniser latency and edge polarity are checked by the bench's behavioural model against every clock. So are readback masking and counter retention across reset, which only a stimulus sequence can reveal.

// File: rtl/art_pkg.sv
package art_pkg;
  localparam int unsigned DW  = 8;             // data / counter width
  localparam int unsigned CW  = 3;             // prescaler code width
  localparam int unsigned AW  = 3;             // register index width
  localparam int unsigned PW  = (1 << CW) - 1; // prescaler counter width

  typedef enum logic [1:0] {
    SRC_CORE = 2'b00,
    SRC_DIV3 = 2'b01,
    SRC_PIN  = 2'b10,
    SRC_OFF  = 2'b11
  } src_e;

  localparam logic [AW-1:0] IX_CTRL  = 3'd0;
  localparam logic [AW-1:0] IX_RELD  = 3'd1;
  localparam logic [AW-1:0] IX_CMP   = 3'd2;
  localparam logic [AW-1:0] IX_CNT   = 3'd3;
  localparam logic [AW-1:0] IX_FLAGS = 3'd4;

  localparam logic [DW-1:0] CTRL_WMASK = 8'hEF; // bit 4 reserved

  // Low 'code' bits set.
  function automatic logic [PW-1:0] tap_mask(input logic [CW-1:0] code);
    return ~({PW{1'b1}} << code);
  endfunction

  // True when the prescaler sits on the last step of a 2^code period.
  function automatic logic tap_hit(input logic [PW-1:0] pc, input logic [CW-1:0] code);
    return &(pc | ~tap_mask(code));
  endfunction
endpackage

// File: rtl/art_srcsel.sv
module art_srcsel
  import art_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  src_e sel,
  output logic src_tick,
  output logic ext_rise,
  output logic ext_fall
);
  localparam int unsigned SH = SYNC_STAGES + 1;

  logic [SH-1:0] sh_q;
  logic [1:0]    m3_q;
  logic          div3_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q[0] <= 1'b0;
    else        sh_q[0] <= ext_in;
  end

  for (genvar i = 1; i < SH; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q[i] <= 1'b0;
      else        sh_q[i] <= sh_q[i-1];
    end
  end

  assign ext_rise = sh_q[SH-2] & ~sh_q[SH-1];
  assign ext_fall = ~sh_q[SH-2] & sh_q[SH-1];

  always_ff @(posedge clk) begin
    if (!rst_n)          m3_q <= 2'd0;
    else if (div3_pulse) m3_q <= 2'd0;
    else                 m3_q <= m3_q + 2'd1;
  end
  assign div3_pulse = (m3_q == 2'd2);

  always_comb begin
    unique case (sel)
      SRC_CORE: src_tick = 1'b1;
      SRC_DIV3: src_tick = div3_pulse;
      SRC_PIN:  src_tick = ext_rise;
      default:  src_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/art_prescale.sv
module art_prescale
  import art_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_tick,
  input  logic [CW-1:0] code,
  output logic          tick
);
  logic [PW-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pc_q <= '0;
    else if (src_tick) pc_q <= pc_q + 1'b1;
  end

  assign tick = src_tick & tap_hit(pc_q, code);
endmodule

// File: rtl/art_counter.sv
module art_counter
  import art_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_wr,
  input  logic [DW-1:0] ld_data,
  input  logic          edge_ev,
  input  logic          tick,
  input  logic [DW-1:0] reload,
  output logic [DW-1:0] count,
  output logic          wrap
);
  localparam logic [DW-1:0] MAXV = '1;

  // No reset: the live count is retained across system reset.
  always_ff @(posedge clk) begin
    if (ld_wr)        count <= ld_data;
    else if (rst_n) begin
      if (edge_ev)    count <= reload;
      else if (tick)  count <= (count == MAXV) ? reload : count + 1'b1;
    end
  end

  assign wrap = rst_n & ~ld_wr & ~edge_ev & tick & (count == MAXV);
endmodule

// File: rtl/art_timer.sv
module art_timer
  import art_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ext_in,
  output logic          cmp_hit,
  output logic          cmp_flag,
  output logic          ovf_flag
);
  logic [DW-1:0] ctrl_q, reload_q, cmp_q, count;
  logic          src_tick, ext_rise, ext_fall, tick, wrap, edge_ev;
  logic          ld_wr, clr_ovf, clr_cmp;
  src_e          src_sel;
  logic [CW-1:0] ps_code;

  assign src_sel = src_e'(ctrl_q[1:0]);
  assign ps_code = ctrl_q[7:5];
  assign ld_wr   = wr_en & (addr == IX_CNT);
  assign clr_ovf = wr_en & (addr == IX_FLAGS) & wdata[0];
  assign clr_cmp = wr_en & (addr == IX_FLAGS) & wdata[1];
  assign edge_ev = ctrl_q[2] & (ctrl_q[3] ? ext_fall : ext_rise);
  assign cmp_hit = (count == cmp_q);

  art_srcsel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .sel(src_sel),
    .src_tick(src_tick), .ext_rise(ext_rise), .ext_fall(ext_fall)
  );

  art_prescale u_ps (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .code(ps_code), .tick(tick)
  );

  art_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_wr(ld_wr), .ld_data(wdata), .edge_ev(edge_ev),
    .tick(tick), .reload(reload_q), .count(count), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (wr_en && addr == IX_CTRL) ctrl_q   <= wdata & CTRL_WMASK;
      if (wr_en && addr == IX_RELD) reload_q <= wdata;
      if (wr_en && addr == IX_CMP)  cmp_q    <= wdata;
      ovf_flag <= wrap    | (ovf_flag & ~clr_ovf);
      cmp_flag <= cmp_hit | (cmp_flag & ~clr_cmp);
    end
  end

  always_comb begin
    unique case (addr)
      IX_CTRL:  rdata = ctrl_q;
      IX_RELD:  rdata = reload_q;
      IX_CMP:   rdata = cmp_q;
      IX_CNT:   rdata = count;
      IX_FLAGS: rdata = {{(DW-2){1'b0}}, cmp_flag, ovf_flag};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/art_chk.sv
module art_chk
  import art_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] count,
  input logic [DW-1:0] reload,
  input logic [DW-1:0] cmp,
  input logic          tick,
  input logic          src_tick,
  input logic          edge_ev,
  input logic          ld_wr,
  input logic [DW-1:0] ld_data,
  input logic          clr_ovf,
  input logic          ovf_flag,
  input logic          cmp_flag,
  input logic [1:0]    src_sel
);
  localparam logic [DW-1:0] MAXV = '1;

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_wr && !edge_ev && count == MAXV) |=> count == $past(reload));

  a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_wr && !edge_ev && count == MAXV) |=> ovf_flag);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  a_r9_cmp_set: assert property (@(posedge clk) disable iff (!rst_n)
    (count == cmp) |=> cmp_flag);

  a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b11 && !ld_wr && !edge_ev) |=> $stable(count));

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> count == $past(ld_data));

  a_r8_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev && !ld_wr) |=> count == $past(reload));

  a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> src_tick);
endmodule

bind art_timer art_chk u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .reload(reload_q), .cmp(cmp_q),
  .tick(tick), .src_tick(src_tick), .edge_ev(edge_ev), .ld_wr(ld_wr),
  .ld_data(wdata), .clr_ovf(clr_ovf), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
  .src_sel(ctrl_q[1:0])
);

// File: tb/sim_art_timer.sv
module sim_art_timer;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, ext_in;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       cmp_hit, cmp_flag, ovf_flag;

  int total = 0, bad = 0;
  bit chk_on = 1'b0, done = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk; // 50 MHz

  art_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_in(ext_in), .cmp_hit(cmp_hit), .cmp_flag(cmp_flag),
    .ovf_flag(ovf_flag)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_ctrl, m_rel, m_cmp, m_cnt, n_cnt;
  bit         m_ovf, m_cmpf, m_s1, m_s2, m_s3;
  int         m_psc, m_m3, code, mask;
  bit         src, tk, rise, fall, ev, ldw, wrapv, clro, clrc;

  always @(posedge clk) begin
    ldw  = wr_en && addr == 3'd3;
    clro = wr_en && addr == 3'd4 && wdata[0];
    clrc = wr_en && addr == 3'd4 && wdata[1];
    if (!rst_n) begin
      m_ctrl = 0; m_rel = 0; m_cmp = 0; m_ovf = 0; m_cmpf = 0;
      m_psc = 0; m_m3 = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      if (ldw) m_cnt = wdata;
    end else begin
      rise = m_s2 && !m_s3;
      fall = !m_s2 && m_s3;
      case (m_ctrl[1:0])
        2'b00: src = 1;
        2'b01: src = (m_m3 == 2);
        2'b10: src = rise;
        default: src = 0;
      endcase
      code = int'(m_ctrl[7:5]);
      mask = (1 << code) - 1;
      tk = src && ((m_psc & mask) == mask);
      ev = m_ctrl[2] && (m_ctrl[3] ? fall : rise);
      n_cnt = m_cnt; wrapv = 0;
      if (ldw) n_cnt = wdata;
      else if (ev) n_cnt = m_rel;
      else if (tk) begin
        if (m_cnt == 8'hFF) begin n_cnt = m_rel; wrapv = 1; end
        else n_cnt = m_cnt + 8'd1;
      end
      m_ovf  = wrapv || (m_ovf && !clro);
      m_cmpf = (m_cnt == m_cmp) || (m_cmpf && !clrc);
      if (src) m_psc = (m_psc + 1) % 128;
      m_m3 = (m_m3 == 2) ? 0 : m_m3 + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
      if (wr_en && addr == 3'd0) m_ctrl = wdata & 8'hEF;
      if (wr_en && addr == 3'd1) m_rel = wdata;
      if (wr_en && addr == 3'd2) m_cmp = wdata;
      m_cnt = n_cnt;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison, mid low phase
  always @(negedge clk) begin
    #5;
    if (chk_on) begin
      case (addr)
        3'd0: chk("R10 ctrl", rdata, m_ctrl);
        3'd1: chk("R10 reload", rdata, m_rel);
        3'd2: chk("R10 compare", rdata, m_cmp);
        3'd3: chk({tag, " count"}, rdata, m_cnt);
        3'd4: chk("R10 flags", rdata, {m_cmpf, m_ovf});
        default: chk("R10 unused", rdata, 0);
      endcase
      chk("R7 ovf_flag", ovf_flag, m_ovf);
      chk("R9 cmp_flag", cmp_flag, m_cmpf);
      chk("R9 cmp_hit", cmp_hit, m_cnt == m_cmp);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 3'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    @(negedge clk); addr = a; #5;
    chk(req, rdata, exp);
  endtask

  task automatic toggle_ext(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = ~ext_in;
      idle(gap + (i % 4));
    end
  endtask

  initial begin
    logic [7:0] held;
    rst_n = 0; wr_en = 0; addr = 3'd3; wdata = 0; ext_in = 0;
    // R5: counter write accepted during reset
    wr(3'd3, 8'h37);
    idle(3);
    rd_chk("R1 count held in reset", 3'd3, 8'h37);
    @(negedge clk); rst_n = 1;
    rd_chk("R1 ctrl after reset", 3'd0, 0);
    chk_on = 1;
    rd_chk("R1 flags after reset", 3'd4, 0);
    rd_chk("R1 reload after reset", 3'd1, 0);

    tag = "R6";
    wr(3'd1, 8'hF0); wr(3'd2, 8'hF8); wr(3'd4, 8'h03);
    idle(300);

    tag = "R7";
    wr(3'd4, 8'h01); idle(20); wr(3'd4, 8'h01); idle(40);

    tag = "R2";
    wr(3'd0, 8'h60); idle(200);
    wr(3'd0, 8'hA0); idle(300);
    wr(3'd0, 8'h20); idle(50);

    tag = "R3";
    wr(3'd0, 8'h01); idle(90);
    wr(3'd0, 8'h22);
    toggle_ext(60, 1);
    wr(3'd0, 8'h03);
    @(negedge clk); addr = 3'd3; #5 held = rdata;
    idle(20); #5;
    chk("R3 stopped count", rdata, held);

    wr(3'd0, 8'hFF);
    rd_chk("R4 reserved bit", 3'd0, 8'hEF);

    tag = "R8";
    wr(3'd1, 8'h40); wr(3'd0, 8'h04);
    toggle_ext(12, 6);
    wr(3'd0, 8'h0C);
    toggle_ext(12, 6);
    wr(3'd0, 8'h2C);
    toggle_ext(12, 3);

    tag = "R5";
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h80); idle(5);
    wr(3'd3, 8'hFE); idle(10);
    rd_chk("R5 readback", 3'd1, 8'h40);

    tag = "R9";
    wr(3'd2, 8'h90); wr(3'd4, 8'h02); idle(100);
    wr(3'd3, 8'h8F); wr(3'd4, 8'h02); idle(10);

    rd_chk("R10 index 5", 3'd5, 0);
    rd_chk("R10 index 7", 3'd7, 0);

    tag = "R1";
    wr(3'd0, 8'h03); wr(3'd3, 8'h5A);
    @(negedge clk); rst_n = 0;
    idle(4);
    rd_chk("R1 count kept through reset", 3'd3, 8'h5A);
    @(negedge clk); rst_n = 1;
    rd_chk("R1 ctrl cleared", 3'd0, 0);
    idle(30);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule